// File: doc/BRIEF.md
# Configuration Address/Data Window Bridge

This block sits on the host side of an indirect configuration scheme. Software first writes a 32-bit selector word through an address window. It then reads or writes the configuration registers of the selected target through a data window. The selector holds a bus number, a device/function number, a register offset and a top-bit enable. The bridge qualifies each data-window access before it forwards anything. The enable must be set, the length must be legal, the offset must fall below the configuration limit, and the target must be present, powered and not hidden. An access that fails any of these checks completes at once, with all ones on a read and nothing forwarded on a write.

An access that qualifies becomes one request on a downstream valid/ready interface. The bridge trims the request length so it never crosses the limit. The data-window access finishes when the downstream response returns, and only one request is in flight at a time. The environment supplies four status flags for the target that the selector currently decodes, so the bridge can judge visibility before it issues a request.

Top module: `cfg_window_bridge`

## Requirements
- R1: The selector register loads from `ap_wdata` only on a write with `ap_off` = 0 and `ap_len` = 4. A write with any other offset or length leaves it unchanged.
- R2: `ap_rdata` always shows the full 32-bit selector, whatever `ap_len` is.
- R3: Selector bit 31 is the enable. While it is 0, a data-window read completes with 0xFFFFFFFF and a data-window write issues no downstream request.
- R4: A forwarded request carries bus = selector[23:16], devfn = selector[15:8] and offset = selector[7:0] OR-ed with `dp_off` (8 bits, so it stays inside 256 bytes). It also carries the write flag and the write data masked to the forwarded length.
- R5: When `tgt_present` is 0, a read returns all ones and a write is dropped.
- R6: An effective offset at or above `CFG_LIMIT` fails: a read returns all ones and a write is dropped. Otherwise the forwarded length is the smaller of `dp_len` and `CFG_LIMIT` minus the offset.
- R7: A target with devfn[2:0] not equal to 0, `tgt_hotadded` = 1 and `tgt_fn0_here` = 0 is hidden and fails the access. A target with `tgt_powered` = 0 also fails. Function 0 itself is never hidden.
- R8: `dp_len` must be 1, 2 or 4; any other value fails the access. A successful read returns the response bytes right-justified, and bits above the forwarded length read as 0.
- R9: `rq_valid` and all request fields stay stable until `rq_ready`. `dp_done` pulses for one cycle: one cycle after the response for a forwarded access, and one cycle after the strobe for a failed access.
- R10: A data-window strobe that arrives while `dp_busy` is 1 is ignored. It produces no request and no `dp_done`.
- R11: After reset the selector is 0 (enable off), `dp_busy` is 0 and `rq_valid` is 0.
- R12: When a selector write and a data-window strobe land in the same cycle, the data access is judged and decoded with the selector value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ap_wr | input | 1 | Address-window write strobe |
| ap_off | input | 2 | Address-window byte offset |
| ap_len | input | 3 | Address-window access length |
| ap_wdata | input | 32 | Address-window write data |
| ap_rdata | output | 32 | Current selector value |
| dp_rd | input | 1 | Data-window read strobe |
| dp_wr | input | 1 | Data-window write strobe (wins if both strobes are high) |
| dp_off | input | 2 | Data-window byte offset |
| dp_len | input | 3 | Data-window access length |
| dp_wdata | input | 32 | Data-window write data |
| dp_busy | output | 1 | A forwarded access is in flight |
| dp_done | output | 1 | One-cycle completion pulse |
| dp_rdata | output | 32 | Read result, valid with dp_done |
| tgt_bus | output | 8 | Bus number decoded from the selector |
| tgt_devfn | output | 8 | Device/function decoded from the selector |
| tgt_present | input | 1 | A device answers at tgt_bus/tgt_devfn |
| tgt_powered | input | 1 | That device is powered |
| tgt_hotadded | input | 1 | That function was hot-added |
| tgt_fn0_here | input | 1 | Function 0 of the same device exists |
| rq_valid | output | 1 | Downstream request valid |
| rq_ready | input | 1 | Downstream request accepted |
| rq_write | output | 1 | Request is a write |
| rq_bus | output | 8 | Request bus number |
| rq_devfn | output | 8 | Request device/function |
| rq_offset | output | 8 | Request register offset |
| rq_len | output | 3 | Request length in bytes, 1 to 4 |
| rq_wdata | output | 32 | Request write data |
| rs_valid | input | 1 | Downstream response valid |
| rs_rdata | input | 32 | Downstream response data |

## Verification
Two functions can meet in one cycle: a selector load through the address window and the launch of a data-window access. The bench provokes this by raising `ap_wr` and `dp_rd` on the same edge. The new selector value clears the enable and points at a different bus. The result counts as correct only if exactly one downstream request appears, carrying the old bus, devfn and offset, and the read data matches the old target's pattern. The bench then reads the selector back and expects the new value.

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge #(
  parameter int CFG_LIMIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ap_wr,
  input  logic [1:0]  ap_off,
  input  logic [2:0]  ap_len,
  input  logic [31:0] ap_wdata,
  output logic [31:0] ap_rdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [1:0]  dp_off,
  input  logic [2:0]  dp_len,
  input  logic [31:0] dp_wdata,
  output logic        dp_busy,
  output logic        dp_done,
  output logic [31:0] dp_rdata,
  output logic [7:0]  tgt_bus,
  output logic [7:0]  tgt_devfn,
  input  logic        tgt_present,
  input  logic        tgt_powered,
  input  logic        tgt_hotadded,
  input  logic        tgt_fn0_here,
  output logic        rq_valid,
  input  logic        rq_ready,
  output logic        rq_write,
  output logic [7:0]  rq_bus,
  output logic [7:0]  rq_devfn,
  output logic [7:0]  rq_offset,
  output logic [2:0]  rq_len,
  output logic [31:0] rq_wdata,
  input  logic        rs_valid,
  input  logic [31:0] rs_rdata
);
  localparam logic [8:0] LIM = 9'(CFG_LIMIT);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} state_t;

  function automatic logic [31:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd1:    lane_mask = 32'h0000_00FF;
      3'd2:    lane_mask = 32'h0000_FFFF;
      3'd3:    lane_mask = 32'h00FF_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  state_t      state;
  logic [31:0] sel_q;

  wire ap_take = ap_wr && (ap_off == 2'd0) && (ap_len == 3'd4);

  assign ap_rdata  = sel_q;
  assign tgt_bus   = sel_q[23:16];
  assign tgt_devfn = sel_q[15:8];

  wire [7:0] eff_off = sel_q[7:0] | {6'b0, dp_off};
  wire       len_ok  = (dp_len == 3'd1) || (dp_len == 3'd2) || (dp_len == 3'd4);
  wire       in_lim  = {1'b0, eff_off} < LIM;
  wire [8:0] remain  = LIM - {1'b0, eff_off};
  wire [2:0] clip_len = ({6'b0, dp_len} > remain) ? remain[2:0] : dp_len;
  wire       hidden  = (tgt_devfn[2:0] != 3'd0) && tgt_hotadded && !tgt_fn0_here;
  wire       qualify = sel_q[31] && len_ok && in_lim && tgt_present && tgt_powered && !hidden;
  wire       start   = (state == S_IDLE) && (dp_rd || dp_wr);

  assign rq_valid = (state == S_REQ);
  assign dp_busy  = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (ap_take) sel_q <= ap_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      dp_done   <= 1'b0;
      dp_rdata  <= '1;
      rq_write  <= 1'b0;
      rq_bus    <= '0;
      rq_devfn  <= '0;
      rq_offset <= '0;
      rq_len    <= 3'd1;
      rq_wdata  <= '0;
    end else begin
      dp_done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (qualify) begin
            state     <= S_REQ;
            rq_write  <= dp_wr;
            rq_bus    <= tgt_bus;
            rq_devfn  <= tgt_devfn;
            rq_offset <= eff_off;
            rq_len    <= clip_len;
            rq_wdata  <= dp_wdata & lane_mask(clip_len);
          end else begin
            dp_done  <= 1'b1;
            dp_rdata <= '1;
          end
        end
        S_REQ: if (rq_ready) state <= S_RSP;
        S_RSP: if (rs_valid) begin
          state    <= S_IDLE;
          dp_done  <= 1'b1;
          dp_rdata <= rs_rdata & lane_mask(rq_len);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_window_bridge_chk.sv
module cfg_window_bridge_chk #(
  parameter int CFG_LIMIT = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ap_rdata,
  input logic        tgt_powered,
  input logic        dp_busy,
  input logic        dp_done,
  input logic        rq_valid,
  input logic        rq_ready,
  input logic        rq_write,
  input logic [7:0]  rq_bus,
  input logic [7:0]  rq_devfn,
  input logic [7:0]  rq_offset,
  input logic [2:0]  rq_len,
  input logic [31:0] rq_wdata
);
  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid &&
      $stable({rq_write, rq_bus, rq_devfn, rq_offset, rq_len, rq_wdata}));

  a_r6_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> ({2'b0, rq_offset} + {7'b0, rq_len}) <= 10'(CFG_LIMIT));

  a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> (rq_len != 3'd0) && (rq_len <= 3'd4));

  a_r3_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_valid) |-> $past(ap_rdata[31]));

  a_r7_power_needed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_valid) |-> $past(tgt_powered));

  a_r9_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dp_done |-> !dp_busy);
endmodule

bind cfg_window_bridge cfg_window_bridge_chk #(.CFG_LIMIT(CFG_LIMIT)) u_chk (.*);

// File: tb/tb_cfg_window_bridge.sv
module tb_cfg_window_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        ap_wr = 0;
  logic [1:0]  ap_off = 0;
  logic [2:0]  ap_len = 0;
  logic [31:0] ap_wdata = 0;
  logic [31:0] ap_rdata;
  logic        dp_rd = 0, dp_wr = 0;
  logic [1:0]  dp_off = 0;
  logic [2:0]  dp_len = 0;
  logic [31:0] dp_wdata = 0;
  logic        dp_busy, dp_done;
  logic [31:0] dp_rdata;
  logic [7:0]  tgt_bus, tgt_devfn;
  logic        tgt_present = 1, tgt_powered = 1, tgt_hotadded = 0, tgt_fn0_here = 1;
  logic        rq_valid, rq_write;
  logic        rq_ready = 0;
  logic [7:0]  rq_bus, rq_devfn, rq_offset;
  logic [2:0]  rq_len;
  logic [31:0] rq_wdata;
  logic        rs_valid = 0;
  logic [31:0] rs_rdata = 0;

  cfg_window_bridge #(.CFG_LIMIT(LIM)) dut (.*);

  int total = 0, bad = 0, req_seen = 0, done_seen = 0, rdy_wait = 0;
  logic [31:0] lat = 0;
  logic [59:0] exp_req[$];
  string       exp_req_tag[$];
  logic [31:0] exp_val[$];
  bit          exp_isrd[$];
  string       exp_tag[$];

  function automatic logic [31:0] mask(input logic [2:0] n);
    case (n)
      3'd1: return 32'h0000_00FF;
      3'd2: return 32'h0000_FFFF;
      3'd3: return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] pattern(input logic [7:0] b, input logic [7:0] d, input logic [7:0] o);
    return {o ^ 8'h3C, d, b, o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : downstream
    logic [59:0] e, a;
    forever begin
      @(negedge clk);
      if (rq_valid) begin
        repeat (rdy_wait) @(negedge clk);
        req_seen++;
        a = {rq_write, rq_bus, rq_devfn, rq_offset, rq_len, rq_wdata};
        total++;
        if (exp_req.size() == 0) begin
          bad++;
          $display("FAIL R3 unexpected request actual=%h expected=none", a);
        end else begin
          string t;
          e = exp_req.pop_front();
          t = exp_req_tag.pop_front();
          if (a !== e) begin
            bad++;
            $display("FAIL %s request actual=%h expected=%h", t, a, e);
          end
        end
        rq_ready = 1;
        @(negedge clk);
        rq_ready = 0;
        rs_rdata = pattern(rq_bus, rq_devfn, rq_offset);
        rs_valid = 1;
        @(negedge clk);
        rs_valid = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && dp_done) begin
      done_seen++;
      if (exp_val.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected completion actual=%h expected=none", dp_rdata);
      end else begin
        logic [31:0] v;
        bit r;
        string t;
        v = exp_val.pop_front();
        r = exp_isrd.pop_front();
        t = exp_tag.pop_front();
        if (r) check(t, dp_rdata, v);
      end
    end
  end

  task automatic ap_write(input logic [1:0] o, input logic [2:0] n, input logic [31:0] v);
    ap_wr = 1; ap_off = o; ap_len = n; ap_wdata = v;
    @(negedge clk);
    ap_wr = 0;
    if (o == 2'd0 && n == 3'd4) lat = v;
  endtask

  task automatic predict(input bit wr, input logic [1:0] o, input logic [2:0] n,
                         input logic [31:0] wd, input string tag);
    logic [7:0] b, d, off;
    logic [2:0] cl;
    int rem;
    bit fail;
    b = lat[23:16]; d = lat[15:8]; off = lat[7:0] | {6'b0, o};
    rem = LIM - int'(off);
    cl = (int'(n) > rem) ? 3'(rem) : n;
    fail = !lat[31] || !(n == 3'd1 || n == 3'd2 || n == 3'd4) || (int'(off) >= LIM) ||
           !tgt_present || !tgt_powered || ((d[2:0] != 3'd0) && tgt_hotadded && !tgt_fn0_here);
    if (!fail) begin
      exp_req.push_back({wr, b, d, off, cl, wd & mask(cl)});
      exp_req_tag.push_back(tag);
    end
    exp_val.push_back(fail ? 32'hFFFF_FFFF : (pattern(b, d, off) & mask(cl)));
    exp_isrd.push_back(!wr);
    exp_tag.push_back(tag);
  endtask

  task automatic dp_access(input bit wr, input logic [1:0] o, input logic [2:0] n,
                           input logic [31:0] wd, input string tag);
    int d0;
    predict(wr, o, n, wd, tag);
    d0 = done_seen;
    dp_wr = wr; dp_rd = !wr; dp_off = o; dp_len = n; dp_wdata = wd;
    @(negedge clk);
    dp_wr = 0; dp_rd = 0;
    while (done_seen == d0) @(negedge clk);
  endtask

  task automatic dropped_write(input logic [1:0] o, input logic [2:0] n, input string tag);
    int r0;
    r0 = req_seen;
    dp_access(1, o, n, 32'hDEAD_BEEF, tag);
    repeat (3) @(negedge clk);
    check(tag, 32'(req_seen), 32'(r0));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 selector", ap_rdata, 32'h0);
    check("R11 busy", 32'(dp_busy), 32'h0);
    check("R11 rq_valid", 32'(rq_valid), 32'h0);
    dp_access(0, 2'd0, 3'd4, 0, "R11 read after reset");

    ap_write(2'd0, 3'd4, 32'h0012_3440);
    check("R1 full write", ap_rdata, 32'h0012_3440);
    ap_write(2'd0, 3'd2, 32'hFFFF_FFFF);
    check("R1 short write", ap_rdata, 32'h0012_3440);
    ap_write(2'd1, 3'd4, 32'hFFFF_FFFF);
    check("R1 offset write", ap_rdata, 32'h0012_3440);
    ap_len = 3'd1;
    @(negedge clk);
    check("R2 narrow readback", ap_rdata, 32'h0012_3440);

    dp_access(0, 2'd0, 3'd4, 0, "R3 disabled read");
    dropped_write(2'd0, 3'd4, "R3 disabled write");

    ap_write(2'd0, 3'd4, 32'h8012_3440);
    dp_access(0, 2'd0, 3'd4, 0, "R4 read len4");
    dp_access(0, 2'd2, 3'd2, 0, "R8 read len2 off2");
    dp_access(0, 2'd3, 3'd1, 0, "R8 read len1 off3");
    rdy_wait = 2;
    dp_access(1, 2'd1, 3'd2, 32'hCAFE_1234, "R4 write len2 off1");
    rdy_wait = 0;
    dp_access(0, 2'd0, 3'd3, 0, "R8 illegal length");

    tgt_present = 0;
    dp_access(0, 2'd0, 3'd4, 0, "R5 absent read");
    dropped_write(2'd0, 3'd4, "R5 absent write");
    tgt_present = 1;

    ap_write(2'd0, 3'd4, 32'h8003_08BC);
    dp_access(0, 2'd1, 3'd4, 0, "R6 clipped read");
    dp_access(1, 2'd1, 3'd4, 32'h1122_3344, "R6 clipped write");
    ap_write(2'd0, 3'd4, 32'h8003_08C0);
    dp_access(0, 2'd0, 3'd1, 0, "R6 at limit read");
    dropped_write(2'd2, 3'd1, "R6 at limit write");

    ap_write(2'd0, 3'd4, 32'h8005_0B20);
    tgt_hotadded = 1; tgt_fn0_here = 0;
    dp_access(0, 2'd0, 3'd4, 0, "R7 hidden read");
    dropped_write(2'd0, 3'd4, "R7 hidden write");
    tgt_fn0_here = 1;
    dp_access(0, 2'd0, 3'd4, 0, "R7 fn0 present read");
    tgt_fn0_here = 0;
    ap_write(2'd0, 3'd4, 32'h8005_0820);
    dp_access(0, 2'd0, 3'd4, 0, "R7 function0 read");
    tgt_hotadded = 0; tgt_fn0_here = 1;
    tgt_powered = 0;
    dp_access(0, 2'd0, 3'd4, 0, "R7 unpowered read");
    tgt_powered = 1;

    begin : busy_case
      int r0;
      rdy_wait = 2;
      r0 = req_seen;
      predict(0, 2'd0, 3'd4, 0, "R10 first read");
      dp_rd = 1; dp_off = 2'd0; dp_len = 3'd4;
      @(negedge clk);
      check("R9 valid raised", 32'(rq_valid), 32'h1);
      dp_off = 2'd1; dp_len = 3'd1;
      @(negedge clk);
      dp_rd = 0;
      repeat (8) @(negedge clk);
      check("R10 one request", 32'(req_seen), 32'(r0 + 1));
      rdy_wait = 0;
    end

    begin : collide
      int r0, d0;
      r0 = req_seen;
      predict(0, 2'd2, 3'd2, 0, "R12 old selector read");
      d0 = done_seen;
      ap_wr = 1; ap_off = 2'd0; ap_len = 3'd4; ap_wdata = 32'h0077_1100;
      dp_rd = 1; dp_off = 2'd2; dp_len = 3'd2;
      @(negedge clk);
      ap_wr = 0; dp_rd = 0;
      lat = 32'h0077_1100;
      while (done_seen == d0) @(negedge clk);
      check("R12 request count", 32'(req_seen), 32'(r0 + 1));
      check("R12 new selector", ap_rdata, 32'h0077_1100);
    end

    repeat (4) @(negedge clk);
    check("R9 queue drained", 32'(exp_val.size() + exp_req.size()), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule